// File: doc/BRIEF.md
# Reset Time-out Sequencer

This block owns the internal reset line of a small microcontroller core. After a power-on detect pulse it keeps the core in reset through two stages that run one after the other. The first is a power-up delay timed in ticks of a slow internal RC clock. The second is a settle count of main-oscillator cycles, which runs only when a crystal or resonator drives the clock. Once the last enabled stage has finished, the reset output is released, synchronous to the main clock.

Two other events can interrupt the sequence. An external active-low reset pin holds the core in reset for as long as it is low. A brown-out flag from a supply comparator holds the core in reset if it stays asserted long enough. When either hold ends, the sequence starts again from its first enabled stage. All inputs come from digital logic in the main clock domain. The RC tick is a one-cycle pulse in that domain.

Top module: `reset_timeout_seq`

## Requirements
- R1: While `rst_ni` is low, `core_rst_o` is 1. After `rst_ni` goes high, `core_rst_o` stays 1 until a start event arrives (a power-on pulse, or `ext_rst_ni` returning high).
- R2: A power-on pulse (`pwr_on_i` high for one cycle) starts the sequence. `core_rst_o` stays 1 until the last enabled stage ends.
- R3: When the power-up stage is used, it ends on the clock edge that samples the `PWRUP_TICKS`-th `rc_tick_i` pulse after the start edge. When `cfg_pwrup_en_i` = 0 and `cfg_brown_en_i` = 0, the stage is skipped.
- R4: When `cfg_brown_en_i` = 1, the power-up stage is used even if `cfg_pwrup_en_i` = 0.
- R5: `cfg_osc_mode_i` encodes 00 = low-power crystal, 01 = crystal, 10 = high-speed crystal, 11 = RC. In the three crystal modes, the settle stage lasts exactly `SETTLE_CYCLES` clock cycles and starts when the power-up stage ends, or at the start edge if that stage is skipped. In RC mode the settle stage is skipped.
- R6: When `cfg_brown_en_i` = 1, a brown-out hold begins one cycle after the edge that counts the `BROWN_TICKS`-th tick seen while `brown_low_i` stays high without a break. A shorter low pulse has no effect. With `cfg_brown_en_i` = 0, `brown_low_i` has no effect.
- R7: A brown-out hold lasts while `brown_low_i` stays high. On the edge that samples it low, the sequence restarts, and it always includes the power-up stage.
- R8: `ext_rst_ni` = 0 holds reset at any point and takes priority over every other event. On the edge that samples it high, the sequence restarts from its first enabled stage. If a brown-out trip is active on that edge, the brown-out hold wins.
- R9: `core_rst_o` falls two clock edges after the sequence ends. When a hold begins, `core_rst_o` rises two edges after the hold state is entered (for example, after the edge that samples `ext_rst_ni` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block itself |
| pwr_on_i | input | 1 | One-cycle power-on detect pulse |
| ext_rst_ni | input | 1 | External reset pin, active low, already synchronous |
| brown_low_i | input | 1 | Supply-below-threshold flag from the comparator |
| rc_tick_i | input | 1 | One-cycle pulse per slow RC clock period |
| cfg_pwrup_en_i | input | 1 | Power-up delay enable |
| cfg_brown_en_i | input | 1 | Brown-out reset enable |
| cfg_osc_mode_i | input | 2 | Oscillator mode: 00 low-power crystal, 01 crystal, 10 high-speed crystal, 11 RC |
| core_rst_o | output | 1 | Reset to the core, active high |

## Verification
Two events can land on the same edge: the external reset pin returning high, and an active brown-out trip. If the trip is ignored, the core restarts while the supply is still low. The bench trips the brown-out filter while the pin is held low, then releases the pin with the supply flag still high. It checks that reset stays asserted for many cycles, long enough to exceed the two-edge release of an RC-mode restart. Later, when the supply flag drops, it checks that the release time includes a full forced power-up delay.

// File: rtl/rts_pkg.sv
package rts_pkg;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_PWRUP,
    ST_SETTLE,
    ST_RUN,
    ST_EXT,
    ST_BROWN
  } seq_state_e;

  typedef enum logic [1:0] {
    OSC_LP = 2'b00,
    OSC_XT = 2'b01,
    OSC_HS = 2'b10,
    OSC_RC = 2'b11
  } osc_mode_e;

endpackage

// File: rtl/rts_event_counter.sv
// Counts inc_i pulses while run_i is high; done_o flags the LIMIT-th one.
module rts_event_counter #(
  parameter int unsigned LIMIT = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic inc_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && inc_i && (cnt_q == CW'(LIMIT - 1));

  // reaching the limit must move the sequencer out of the stage
  AST_CNT_LEAVES_STAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CW'(LIMIT)) |-> !run_i); // R3 R5

endmodule

// File: rtl/rts_brown_filter.sv
// Minimum-duration filter on the supply-low flag, timed in RC ticks.
module rts_brown_filter #(
  parameter int unsigned TICKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic low_i,
  input  logic tick_i,
  output logic trip_o
);
  localparam int unsigned CW = $clog2(TICKS + 1);

  logic [CW-1:0] cnt_q;
  logic          armed;

  assign armed = en_i && low_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_q <= '0;
    else if (!armed)                       cnt_q <= '0;
    else if (tick_i && cnt_q != CW'(TICKS)) cnt_q <= cnt_q + 1'b1;
  end

  // live flag gates the output so the hold ends on the edge the flag clears
  assign trip_o = armed && (cnt_q == CW'(TICKS));

  AST_TRIP_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trip_o) |-> $past(low_i && tick_i)); // R6

endmodule

// File: rtl/rts_rel_sync.sv
// Two-flop release path: reset asserted at once by rst_ni, released on clk_i.
module rts_rel_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic rst_o
);
  logic q1, q2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q1 <= 1'b0;
      q2 <= 1'b0;
    end else begin
      q1 <= run_i;
      q2 <= q1;
    end
  end

  assign rst_o = ~q2;

endmodule

// File: rtl/reset_timeout_seq.sv
module reset_timeout_seq
  import rts_pkg::*;
#(
  parameter int unsigned PWRUP_TICKS   = 1440,
  parameter int unsigned BROWN_TICKS   = 2,
  parameter int unsigned SETTLE_CYCLES = 1024
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_on_i,
  input  logic       ext_rst_ni,
  input  logic       brown_low_i,
  input  logic       rc_tick_i,
  input  logic       cfg_pwrup_en_i,
  input  logic       cfg_brown_en_i,
  input  logic [1:0] cfg_osc_mode_i,
  output logic       core_rst_o
);

  seq_state_e state_q, state_d;
  seq_state_e first_stage, after_pwrup;
  logic       pwrup_use, xtal;
  logic       pwrup_done, settle_done, brown_trip;

  assign pwrup_use = cfg_pwrup_en_i || cfg_brown_en_i;
  assign xtal      = (cfg_osc_mode_i != OSC_RC);

  rts_event_counter #(.LIMIT(PWRUP_TICKS)) i_pwrup_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q == ST_PWRUP),
    .inc_i  (rc_tick_i),
    .done_o (pwrup_done)
  );

  rts_event_counter #(.LIMIT(SETTLE_CYCLES)) i_settle_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q == ST_SETTLE),
    .inc_i  (1'b1),
    .done_o (settle_done)
  );

  rts_brown_filter #(.TICKS(BROWN_TICKS)) i_brown_flt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cfg_brown_en_i),
    .low_i  (brown_low_i),
    .tick_i (rc_tick_i),
    .trip_o (brown_trip)
  );

  always_comb begin
    after_pwrup = xtal ? ST_SETTLE : ST_RUN;
    first_stage = pwrup_use ? ST_PWRUP : after_pwrup;
    state_d     = state_q;
    // priority: external pin, then brown-out, then sequence progress
    if (!ext_rst_ni)     state_d = ST_EXT;
    else if (brown_trip) state_d = ST_BROWN;
    else begin
      unique case (state_q)
        ST_WAIT, ST_RUN: if (pwr_on_i)     state_d = first_stage;
        ST_EXT:                            state_d = first_stage;
        ST_BROWN:        if (!brown_low_i) state_d = first_stage;
        ST_PWRUP:        if (pwrup_done)   state_d = after_pwrup;
        ST_SETTLE:       if (settle_done)  state_d = ST_RUN;
        default:                           state_d = ST_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_WAIT;
    else         state_q <= state_d;
  end

  rts_rel_sync i_rel_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q == ST_RUN),
    .rst_o  (core_rst_o)
  );

  AST_EXT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_rst_ni |-> ##3 core_rst_o); // R8

  AST_RC_NO_SETTLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_SETTLE && cfg_osc_mode_i == OSC_RC) |=> state_q != ST_SETTLE); // R5

  AST_BROWN_FORCES_PWRUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && pwr_on_i && ext_rst_ni && !brown_trip && cfg_brown_en_i)
      |=> state_q == ST_PWRUP); // R4

  AST_SYNC_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_rst_o) |-> $past(state_q == ST_RUN, 2)); // R9

  AST_NO_RUN_WITHOUT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !pwr_on_i) |=> state_q != ST_RUN); // R1

endmodule

// File: tb/test_reset_timeout_seq.sv
module test_reset_timeout_seq;
  localparam int unsigned PWRUP_TICKS   = 6;
  localparam int unsigned BROWN_TICKS   = 4;
  localparam int unsigned SETTLE_CYCLES = 1024;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pwr_on_i = 1'b0;
  logic       ext_rst_ni = 1'b1;
  logic       brown_low_i = 1'b0;
  logic       rc_tick_i = 1'b0;
  logic       cfg_pwrup_en_i = 1'b0;
  logic       cfg_brown_en_i = 1'b0;
  logic [1:0] cfg_osc_mode_i = 2'b11;
  logic       core_rst_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  reset_timeout_seq #(
    .PWRUP_TICKS(PWRUP_TICKS), .BROWN_TICKS(BROWN_TICKS), .SETTLE_CYCLES(SETTLE_CYCLES)
  ) i_reset_timeout_seq (
    .clk_i, .rst_ni, .pwr_on_i, .ext_rst_ni, .brown_low_i, .rc_tick_i,
    .cfg_pwrup_en_i, .cfg_brown_en_i, .cfg_osc_mode_i, .core_rst_o
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_release(int pw_end, bit xtal);
    return pw_end + (xtal ? int'(SETTLE_CYCLES) : 0) + 2;
  endfunction

  // caller has set the start condition at a negedge with rc_tick_i = 0
  task automatic measure(string req, bit pw_use, bit xtal);
    int k = 0, tc = 0, first_low = -1;
    int pw_end = pw_use ? -1 : 0;
    bit t;
    while (first_low < 0 && k < 3000) begin
      @(negedge clk_i);
      pwr_on_i = 1'b0;
      if (!core_rst_o) first_low = k;
      else begin
        t = ($urandom % 3) == 0;
        rc_tick_i = t;
        if (pw_end < 0 && t) begin
          tc++;
          if (tc == int'(PWRUP_TICKS)) pw_end = k + 1;
        end
        k++;
      end
    end
    rc_tick_i = 1'b0;
    chk(req, first_low, exp_release(pw_end, xtal));
  endtask

  task automatic hold_check(string req, int n, bit exp);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      rc_tick_i = ($urandom % 2) == 0;
      if (core_rst_o != exp) bad++;
    end
    @(negedge clk_i);
    rc_tick_i = 1'b0;
    chk(req, (bad > 0) ? int'(!exp) : int'(exp), int'(exp));
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; pwr_on_i = 1'b0; ext_rst_ni = 1'b1;
    brown_low_i = 1'b0; rc_tick_i = 1'b0;
    @(negedge clk_i);
    chk("R1 reset active", core_rst_o, 1);
    rst_ni = 1'b1;
  endtask

  task automatic start_seq(bit pw, bit br, logic [1:0] mode, string req);
    do_reset();
    @(negedge clk_i);
    cfg_pwrup_en_i = pw; cfg_brown_en_i = br; cfg_osc_mode_i = mode;
    pwr_on_i = 1'b1; rc_tick_i = 1'b0;
    measure(req, pw | br, mode != 2'b11);
  endtask

  // brown_low_i high, then BROWN_TICKS back-to-back ticks; optional edge check
  task automatic trip_brown(bit check_edges);
    @(negedge clk_i);
    brown_low_i = 1'b1; rc_tick_i = 1'b0;
    for (int i = 0; i < int'(BROWN_TICKS); i++) begin
      @(negedge clk_i);
      rc_tick_i = 1'b1;
    end
    @(negedge clk_i);
    rc_tick_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    if (check_edges) chk("R6 R9 reset not yet raised", core_rst_o, 0);
    @(negedge clk_i);
    if (check_edges) chk("R6 R9 brown-out raises reset", core_rst_o, 1);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    chk("R1 reset during rst_ni", core_rst_o, 1);
    rst_ni = 1'b1;
    hold_check("R1 no release without start", 40, 1'b1);

    // directed stage combinations
    start_seq(1'b1, 1'b0, 2'b01, "R2 R3 power-up then settle (crystal)");
    start_seq(1'b0, 1'b0, 2'b00, "R3 R5 settle only (low-power crystal)");
    start_seq(1'b0, 1'b0, 2'b11, "R5 RC skips both stages");
    start_seq(1'b0, 1'b1, 2'b10, "R4 brown enable forces power-up");
    start_seq(1'b1, 1'b0, 2'b11, "R3 R5 power-up only in RC");
    for (int i = 0; i < 8; i++) begin
      logic [1:0] m;
      m = 2'($urandom % 4);
      start_seq(1'($urandom % 2), 1'($urandom % 2), m, "R2 R3 R4 R5 random config");
    end

    // external reset mid-sequence and in run
    do_reset();
    @(negedge clk_i);
    cfg_pwrup_en_i = 1'b1; cfg_brown_en_i = 1'b0; cfg_osc_mode_i = 2'b10;
    pwr_on_i = 1'b1;
    @(negedge clk_i); pwr_on_i = 1'b0;
    repeat (2) @(negedge clk_i);
    ext_rst_ni = 1'b0;
    hold_check("R8 held by external reset", 50, 1'b1);
    @(negedge clk_i); ext_rst_ni = 1'b1; rc_tick_i = 1'b0;
    measure("R8 restart after external reset", 1'b1, 1'b1);
    repeat (3) @(negedge clk_i);
    ext_rst_ni = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R9 external reset, one edge later", core_rst_o, 0);
    @(negedge clk_i);
    chk("R9 external reset, two edges later", core_rst_o, 1);
    hold_check("R8 external reset held in run", 20, 1'b1);
    @(negedge clk_i); ext_rst_ni = 1'b1; rc_tick_i = 1'b0;
    measure("R8 restart from run", 1'b1, 1'b1);

    // brown-out
    start_seq(1'b0, 1'b1, 2'b11, "R4 brown enable, RC");
    @(negedge clk_i);
    brown_low_i = 1'b1;
    for (int i = 0; i < int'(BROWN_TICKS) - 1; i++) begin
      @(negedge clk_i); rc_tick_i = 1'b1;
      @(negedge clk_i); rc_tick_i = 1'b0;
    end
    @(negedge clk_i); brown_low_i = 1'b0;
    hold_check("R6 short low pulse ignored", 10, 1'b0);
    trip_brown(1'b1);
    hold_check("R7 held while supply low", 30, 1'b1);
    @(negedge clk_i); brown_low_i = 1'b0; rc_tick_i = 1'b0;
    measure("R7 restart with forced power-up", 1'b1, 1'b0);
    @(negedge clk_i);
    cfg_brown_en_i = 1'b0; brown_low_i = 1'b1;
    hold_check("R6 disabled brown-out ignored", 40, 1'b0);
    @(negedge clk_i); brown_low_i = 1'b0; cfg_brown_en_i = 1'b1;

    // external release coinciding with an active brown-out trip
    @(negedge clk_i); ext_rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    trip_brown(1'b0);
    @(negedge clk_i); ext_rst_ni = 1'b1;
    hold_check("R8 trip wins over external release", 30, 1'b1);
    @(negedge clk_i); brown_low_i = 1'b0; rc_tick_i = 1'b0;
    measure("R7 R8 restart after trip clears", 1'b1, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule